// File: doc/BRIEF.md
# Layered CPU Bank Resolver

This block sits between a 16-bit CPU core and a 28-bit physical address space. For each CPU access it resolves the address and the read/write direction into one of three things: a physical RAM address, an address inside a ROM image, or a special target such as the IO page, a cartridge window or unmapped space. The resolution is combinational from the current inputs and the stored write-protect state. It also reports whether a write may commit.

Four banking schemes are stacked in a fixed order, and each one can override the one before it:
- Processor-port bits expose legacy ROM images.
- A per-slab MAP remap moves any of the eight 8 KB slabs by a 256-byte-granular offset, one offset for the low half of the CPU space and one for the high half.
- A ROM-bank register exposes enhanced ROM images and beats both of the above.
- IO and cartridge overlays are applied last.

All ROM images live in ordinary RAM between $20000 and $3FFFF. That region is guarded by a write-protect flag, which resets to set and flips on each toggle request.

Top module: `bank_resolver`

## Requirements
- R1: Target codes are RAM=0, ROM=1, IO=2, CART_LO=3, CART_HI=4, OPEN=5, PORT=6. With port bits, MAP enables, ROM-bank bits and cartridge mode all zero, every access targets RAM at the zero-extended CPU address (PORT for physical 0 and 1).
- R2: Port bits are bit0 = low select, bit1 = high select, bit2 = IO select. A read of $A000-$BFFF with bit0 and bit1 both set gives ROM at $2A000 + offset. A read of $E000-$FFFF with bit1 set gives ROM at $2E000 + offset. At $D000-$DFFF, when bit0 or bit1 is set, the result is IO if bit2 is set and otherwise ROM at $2D000 + offset. Port value $35 therefore yields RAM everywhere except IO at $D000-$DFFF.
- R3: When MAP enable bit n is set for slab n (address bits 15:13 = n), the physical address is offset*256 + CPU address, truncated to 20 bits and zero-extended. The offset is the low-half offset for slabs 0-3 and the high-half offset for slabs 4-7. An enabled slab cancels port-bit ROM in that slab.
- R4: ROM-bank bits override MAP and port ROM on reads. Bit0 maps $6000-$7FFF to $30000. Bit1 maps $8000-$BFFF to $20000. Bit2 maps $C000-$CFFF to $2C000. Bit3 maps $E000-$FFFF to $3E000. In each case the offset within the window is kept.
- R5: A write never targets ROM. A write to an address shadowed by ROM goes to the RAM that MAP, or the direct CPU address, gives for it.
- R6: write_ok is high only for writes. It is low for a write whose RAM target lies in $20000-$3FFFF while write-protect is set.
- R7: Write-protect is set after reset and flips once for each clock cycle in which the toggle request is high.
- R8: IO and cartridge overlays override all other layers. Their physical address output is the zero-extended CPU address.
- R9: In cartridge mode 1 or 2, a read of $8000-$9FFF with port bits 0 and 1 both set targets CART_LO. In mode 2, a read of $A000-$BFFF with port bit 1 set targets CART_HI. Writes to these windows fall through to the lower layers.
- R10: In cartridge mode 3, $0000-$0FFF resolves through the lower layers. $8000-$9FFF is CART_LO, $D000-$DFFF is IO and $E000-$FFFF is CART_HI, for either direction. Every other address is OPEN.
- R11: A RAM result at physical address 0 or 1, reached directly or through MAP, targets PORT.
- R12: Arbitrary combinations of all inputs resolve according to the layer order given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| port_bits_i | input | 3 | Processor-port banking bits |
| map_en_i | input | 8 | Per-slab MAP enables |
| map_lo_ofs_i | input | 12 | MAP offset for slabs 0-3, in 256-byte units |
| map_hi_ofs_i | input | 12 | MAP offset for slabs 4-7, in 256-byte units |
| rom_sel_i | input | 4 | ROM-bank register bits |
| cart_mode_i | input | 2 | Cartridge mode: 0 none, 1 low, 2 both, 3 hide memory |
| wp_toggle_i | input | 1 | Write-protect toggle request |
| phys_addr_o | output | 28 | Resolved physical address |
| target_o | output | 3 | Target class code |
| write_ok_o | output | 1 | Write may commit |

## Verification
The assertions check the following on every cycle:
- write_ok is never raised for a read, and is never raised for a protected write into the image region.
- A write never resolves to ROM.
- A PORT target carries physical address 0 or 1.
- Hide-memory mode leaves $1000-$7FFF open.
- The protect flag flips exactly on toggle cycles and holds otherwise.

The exact addresses produced by each layer can only be shown by the bench's scenarios. The same applies to the override order between port ROM, MAP, ROM-bank and overlays, the 20-bit wrap of a MAP sum, and the fall-through of shadowed writes.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int CPU_AW  = 16;
  localparam int PHYS_AW = 28;
  localparam int MAP_AW  = 20;
  localparam int SLABS   = 8;
  localparam int OFS_W   = 12;
  localparam int ROM_SEL_W = 4;

  typedef enum logic [2:0] {
    TGT_RAM     = 3'd0,
    TGT_ROM     = 3'd1,
    TGT_IO      = 3'd2,
    TGT_CART_LO = 3'd3,
    TGT_CART_HI = 3'd4,
    TGT_OPEN    = 3'd5,
    TGT_PORT    = 3'd6
  } target_e;

  typedef enum logic [1:0] {
    CART_NONE = 2'd0,
    CART_LO8  = 2'd1,
    CART_BOTH = 2'd2,
    CART_HIDE = 2'd3
  } cart_mode_e;

  typedef struct packed {
    logic               hit;
    logic [PHYS_AW-1:0] addr;
  } layer_t;

  // image locations inside chip RAM
  localparam logic [PHYS_AW-1:0] IMG_LO       = 28'h002_0000;
  localparam logic [PHYS_AW-1:0] IMG_HI       = 28'h003_FFFF;
  localparam logic [PHYS_AW-1:0] LEG_BASIC_B  = 28'h002_A000;
  localparam logic [PHYS_AW-1:0] LEG_CHAR_B   = 28'h002_D000;
  localparam logic [PHYS_AW-1:0] LEG_KERN_B   = 28'h002_E000;
  localparam logic [PHYS_AW-1:0] ENH_MON_B    = 28'h003_0000;
  localparam logic [PHYS_AW-1:0] ENH_DOS_B    = 28'h002_0000;
  localparam logic [PHYS_AW-1:0] ENH_IFC_B    = 28'h002_C000;
  localparam logic [PHYS_AW-1:0] ENH_KERN_B   = 28'h003_E000;
endpackage

// File: rtl/bank_wp_reg.sv
module bank_wp_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic toggle_i,
  output logic wp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wp_o <= 1'b1;
    else if (toggle_i) wp_o <= ~wp_o;
  end
endmodule

// File: rtl/bank_port_layer.sv
module bank_port_layer
  import bank_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int PAW = PHYS_AW
) (
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    port_bits_i,
  output layer_t        rom_o,
  output logic          io_sel_o
);
  logic sel_lo, sel_hi, sel_io;
  assign sel_lo = port_bits_i[0];
  assign sel_hi = port_bits_i[1];
  assign sel_io = port_bits_i[2];

  always_comb begin
    rom_o    = '0;
    io_sel_o = 1'b0;
    unique case (addr_i[AW-1 -: 3])
      3'd5: if (sel_lo && sel_hi) begin
        rom_o.hit  = 1'b1;
        rom_o.addr = LEG_BASIC_B | PAW'(addr_i[12:0]);
      end
      3'd6: if (addr_i[12] && (sel_lo || sel_hi)) begin
        if (sel_io) io_sel_o = 1'b1;
        else begin
          rom_o.hit  = 1'b1;
          rom_o.addr = LEG_CHAR_B | PAW'(addr_i[11:0]);
        end
      end
      3'd7: if (sel_hi) begin
        rom_o.hit  = 1'b1;
        rom_o.addr = LEG_KERN_B | PAW'(addr_i[12:0]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bank_map_layer.sv
module bank_map_layer
  import bank_pkg::*;
#(
  parameter int AW    = CPU_AW,
  parameter int PAW   = PHYS_AW,
  parameter int MW    = MAP_AW,
  parameter int NSLAB = SLABS,
  parameter int OW    = OFS_W
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [NSLAB-1:0] en_i,
  input  logic [OW-1:0]    lo_ofs_i,
  input  logic [OW-1:0]    hi_ofs_i,
  output layer_t           map_o
);
  localparam int SW = $clog2(NSLAB);
  localparam int SH = MW - OW;

  logic [NSLAB-1:0] slab_hit;
  logic [OW-1:0]    ofs;
  logic [MW-1:0]    sum;

  for (genvar s = 0; s < NSLAB; s++) begin : g_slab
    assign slab_hit[s] = en_i[s] && (addr_i[AW-1 -: SW] == SW'(s));
  end

  assign ofs = addr_i[AW-1] ? hi_ofs_i : lo_ofs_i;
  assign sum = {ofs, {SH{1'b0}}} + MW'(addr_i);

  assign map_o.hit  = |slab_hit;
  assign map_o.addr = PAW'(sum);
endmodule

// File: rtl/bank_rom_layer.sv
module bank_rom_layer
  import bank_pkg::*;
#(
  parameter int AW  = CPU_AW,
  parameter int PAW = PHYS_AW,
  parameter int RW  = ROM_SEL_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] sel_i,
  output layer_t        rom_o
);
  always_comb begin
    rom_o = '0;
    if (sel_i[0] && addr_i[AW-1 -: 3] == 3'd3) begin
      rom_o.hit  = 1'b1;
      rom_o.addr = ENH_MON_B | PAW'(addr_i[12:0]);
    end else if (sel_i[1] && addr_i[AW-1 -: 2] == 2'b10) begin
      rom_o.hit  = 1'b1;
      rom_o.addr = ENH_DOS_B | PAW'(addr_i[13:0]);
    end else if (sel_i[2] && addr_i[AW-1 -: 4] == 4'hC) begin
      rom_o.hit  = 1'b1;
      rom_o.addr = ENH_IFC_B | PAW'(addr_i[11:0]);
    end else if (sel_i[3] && addr_i[AW-1 -: 3] == 3'd7) begin
      rom_o.hit  = 1'b1;
      rom_o.addr = ENH_KERN_B | PAW'(addr_i[12:0]);
    end
  end
endmodule

// File: rtl/bank_overlay.sv
module bank_overlay
  import bank_pkg::*;
(
  input  logic [3:0] page_i,
  input  logic       we_i,
  input  logic       port_lo_i,
  input  logic       port_hi_i,
  input  logic       io_sel_i,
  input  cart_mode_e cart_mode_i,
  output logic       hit_o,
  output target_e    tgt_o
);
  logic in_lo_win, in_hi16_win;
  assign in_lo_win   = (page_i == 4'h8) || (page_i == 4'h9);
  assign in_hi16_win = (page_i == 4'hA) || (page_i == 4'hB);

  always_comb begin
    hit_o = 1'b0;
    tgt_o = TGT_RAM;
    if (cart_mode_i == CART_HIDE) begin
      hit_o = (page_i != 4'h0);
      if (in_lo_win)            tgt_o = TGT_CART_LO;
      else if (page_i >= 4'hE) tgt_o = TGT_CART_HI;
      else if (page_i == 4'hD) tgt_o = TGT_IO;
      else                      tgt_o = TGT_OPEN;
    end else if (io_sel_i) begin
      hit_o = 1'b1;
      tgt_o = TGT_IO;
    end else if (!we_i && in_lo_win && port_lo_i && port_hi_i &&
                 cart_mode_i != CART_NONE) begin
      hit_o = 1'b1;
      tgt_o = TGT_CART_LO;
    end else if (!we_i && in_hi16_win && port_hi_i && cart_mode_i == CART_BOTH) begin
      hit_o = 1'b1;
      tgt_o = TGT_CART_HI;
    end
  end
endmodule

// File: rtl/bank_resolver.sv
module bank_resolver
  import bank_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CPU_AW-1:0]    cpu_addr_i,
  input  logic                 cpu_we_i,
  input  logic [2:0]           port_bits_i,
  input  logic [SLABS-1:0]     map_en_i,
  input  logic [OFS_W-1:0]     map_lo_ofs_i,
  input  logic [OFS_W-1:0]     map_hi_ofs_i,
  input  logic [ROM_SEL_W-1:0] rom_sel_i,
  input  logic [1:0]           cart_mode_i,
  input  logic                 wp_toggle_i,
  output logic [PHYS_AW-1:0]   phys_addr_o,
  output logic [2:0]           target_o,
  output logic                 write_ok_o
);
  layer_t             port_rom, map_l, rom_l;
  logic               io_sel, ovl_hit, wp_q;
  target_e            ovl_tgt, tgt;
  logic [PHYS_AW-1:0] ram_addr, phys;
  cart_mode_e         cmode;

  assign cmode = cart_mode_e'(cart_mode_i);

  bank_wp_reg u_wp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .toggle_i(wp_toggle_i),
    .wp_o    (wp_q)
  );

  bank_port_layer u_port (
    .addr_i     (cpu_addr_i),
    .port_bits_i(port_bits_i),
    .rom_o      (port_rom),
    .io_sel_o   (io_sel)
  );

  bank_map_layer u_map (
    .addr_i  (cpu_addr_i),
    .en_i    (map_en_i),
    .lo_ofs_i(map_lo_ofs_i),
    .hi_ofs_i(map_hi_ofs_i),
    .map_o   (map_l)
  );

  bank_rom_layer u_rom (
    .addr_i(cpu_addr_i),
    .sel_i (rom_sel_i),
    .rom_o (rom_l)
  );

  bank_overlay u_ovl (
    .page_i     (cpu_addr_i[CPU_AW-1 -: 4]),
    .we_i       (cpu_we_i),
    .port_lo_i  (port_bits_i[0]),
    .port_hi_i  (port_bits_i[1]),
    .io_sel_i   (io_sel),
    .cart_mode_i(cmode),
    .hit_o      (ovl_hit),
    .tgt_o      (ovl_tgt)
  );

  assign ram_addr = map_l.hit ? map_l.addr : PHYS_AW'(cpu_addr_i);

  // priority: overlays > ROM-bank > MAP > port ROM; ROM sources ignored on writes
  always_comb begin
    if (ovl_hit) begin
      tgt  = ovl_tgt;
      phys = PHYS_AW'(cpu_addr_i);
    end else if (!cpu_we_i && rom_l.hit) begin
      tgt  = TGT_ROM;
      phys = rom_l.addr;
    end else if (!cpu_we_i && port_rom.hit && !map_l.hit) begin
      tgt  = TGT_ROM;
      phys = port_rom.addr;
    end else begin
      tgt  = (ram_addr < PHYS_AW'(2)) ? TGT_PORT : TGT_RAM;
      phys = ram_addr;
    end
  end

  assign phys_addr_o = phys;
  assign target_o    = tgt;
  assign write_ok_o  = cpu_we_i &&
                       !(wp_q && tgt == TGT_RAM && phys >= IMG_LO && phys <= IMG_HI);
endmodule

// File: rtl/bank_resolver_chk.sv
module bank_resolver_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_we_i,
  input logic [1:0]  cart_mode_i,
  input logic        wp_toggle_i,
  input logic [27:0] phys_addr_o,
  input logic [2:0]  target_o,
  input logic        write_ok_o,
  input logic        wp_q
);
  assert_wok_only_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_ok_o |-> cpu_we_i);

  assert_wok_protect_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_we_i && wp_q && target_o == 3'd0 &&
     phys_addr_o >= 28'h20000 && phys_addr_o <= 28'h3FFFF) |-> !write_ok_o);

  assert_no_rom_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i |-> target_o != 3'd1);

  assert_port_addr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    target_o == 3'd6 |-> phys_addr_o < 28'd2);

  assert_hide_open_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cart_mode_i == 2'd3 && cpu_addr_i[15:12] >= 4'h1 && cpu_addr_i[15:12] <= 4'h7)
    |-> target_o == 3'd5);

  assert_wp_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_toggle_i |=> wp_q != $past(wp_q));

  assert_wp_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_toggle_i |=> $stable(wp_q));
endmodule

bind bank_resolver bank_resolver_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpu_addr_i (cpu_addr_i),
  .cpu_we_i   (cpu_we_i),
  .cart_mode_i(cart_mode_i),
  .wp_toggle_i(wp_toggle_i),
  .phys_addr_o(phys_addr_o),
  .target_o   (target_o),
  .write_ok_o (write_ok_o),
  .wp_q       (wp_q)
);

// File: tb/bank_resolver_tb.sv
module bank_resolver_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        we = 1'b0;
  logic [2:0]  pb = '0;
  logic [7:0]  men = '0;
  logic [11:0] lofs = '0, hofs = '0;
  logic [3:0]  rs = '0;
  logic [1:0]  cm = '0;
  logic        tog = 1'b0;
  logic [27:0] phys;
  logic [2:0]  tgt;
  logic        wok;

  int checks = 0, errors = 0;
  logic wp_m = 1'b1;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_resolver u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_we_i(we),
    .port_bits_i(pb), .map_en_i(men), .map_lo_ofs_i(lofs), .map_hi_ofs_i(hofs),
    .rom_sel_i(rs), .cart_mode_i(cm), .wp_toggle_i(tog),
    .phys_addr_o(phys), .target_o(tgt), .write_ok_o(wok)
  );

  function automatic logic [31:0] model(input logic [15:0] a, input logic w,
      input logic [2:0] p, input logic [7:0] me, input logic [11:0] lo, input logic [11:0] hi,
      input logic [3:0] r, input logic [1:0] c, input logic wp);
    logic [27:0] az, ram, ra, pa, ph;
    logic [19:0] m;
    logic rh, phit, io, ovl, ok;
    logic [2:0] t;
    az  = {12'h0, a};
    m   = {(a[15] ? hi : lo), 8'h00} + {4'h0, a};
    ram = me[a[15:13]] ? {8'h0, m} : az;
    rh = 1'b0; ra = '0;
    if (r[0] && a >= 16'h6000 && a <= 16'h7FFF) begin rh = 1; ra = 28'h30000 + az - 28'h6000; end
    else if (r[1] && a >= 16'h8000 && a <= 16'hBFFF) begin rh = 1; ra = 28'h20000 + az - 28'h8000; end
    else if (r[2] && a >= 16'hC000 && a <= 16'hCFFF) begin rh = 1; ra = 28'h2C000 + az - 28'hC000; end
    else if (r[3] && a >= 16'hE000) begin rh = 1; ra = 28'h3E000 + az - 28'hE000; end
    phit = 1'b0; pa = '0;
    io = (a[15:12] == 4'hD) && (p[0] || p[1]) && p[2];
    if (a >= 16'hA000 && a <= 16'hBFFF && p[0] && p[1]) begin phit = 1; pa = 28'h2A000 + az - 28'hA000; end
    if (a[15:12] == 4'hD && (p[0] || p[1]) && !p[2]) begin phit = 1; pa = 28'h2D000 + az - 28'hD000; end
    if (a >= 16'hE000 && p[1]) begin phit = 1; pa = 28'h2E000 + az - 28'hE000; end
    ovl = 1'b1; t = 3'd0;
    if (c == 2'd3) begin
      if (a < 16'h1000) ovl = 1'b0;
      else if (a >= 16'h8000 && a <= 16'h9FFF) t = 3'd3;
      else if (a >= 16'hE000) t = 3'd4;
      else if (a[15:12] == 4'hD) t = 3'd2;
      else t = 3'd5;
    end else if (io) t = 3'd2;
    else if (!w && c != 0 && a >= 16'h8000 && a <= 16'h9FFF && p[0] && p[1]) t = 3'd3;
    else if (!w && c == 2 && a >= 16'hA000 && a <= 16'hBFFF && p[1]) t = 3'd4;
    else ovl = 1'b0;
    if (ovl) ph = az;
    else if (!w && rh) begin t = 3'd1; ph = ra; end
    else if (!w && phit && !me[a[15:13]]) begin t = 3'd1; ph = pa; end
    else begin ph = ram; t = (ram < 2) ? 3'd6 : 3'd0; end
    ok = w && !(wp && t == 3'd0 && ph >= 28'h20000 && ph <= 28'h3FFFF);
    return {t, ph, ok};
  endfunction

  task automatic apply_check(input string tag);
    logic [31:0] e;
    @(negedge clk);
    #1;
    e = model(addr, we, pb, men, lofs, hofs, rs, cm, wp_m);
    checks++;
    if ({tgt, phys, wok} !== e) begin
      errors++;
      $display("FAIL %s addr=%h we=%0d: got tgt=%0d phys=%h wok=%0d, exp tgt=%0d phys=%h wok=%0d",
               tag, addr, we, tgt, phys, wok, e[31:29], e[28:1], e[0]);
    end
  endtask

  task automatic direct(input string tag, input logic [2:0] et, input logic [27:0] ep, input logic ew);
    @(negedge clk);
    #1;
    checks++;
    if (tgt !== et || phys !== ep || wok !== ew) begin
      errors++;
      $display("FAIL %s addr=%h: got tgt=%0d phys=%h wok=%0d, exp tgt=%0d phys=%h wok=%0d",
               tag, addr, tgt, phys, wok, et, ep, ew);
    end
  endtask

  task automatic toggle_wp();
    @(negedge clk); tog = 1'b1;
    @(negedge clk); tog = 1'b0;
    wp_m = ~wp_m;
  endtask

  task automatic clear_all();
    we = 0; pb = 0; men = 0; lofs = 0; hofs = 0; rs = 0; cm = 0;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state: protect set (R7)
    clear_all(); men = 8'h02; lofs = 12'h200; addr = 16'h2010; we = 1;
    direct("R7", 3'd0, 28'h22010, 1'b0);
    // R1
    clear_all(); addr = 16'hE123; direct("R1", 3'd0, 28'h0E123, 1'b0);
    addr = 16'h0001; direct("R11", 3'd6, 28'h1, 1'b0);
    // R2
    pb = 3'b111; addr = 16'hE010; direct("R2", 3'd1, 28'h2E010, 1'b0);
    addr = 16'hA005; direct("R2", 3'd1, 28'h2A005, 1'b0);
    addr = 16'hD020; direct("R2", 3'd2, 28'h0D020, 1'b0);
    pb = 3'b011; direct("R2", 3'd1, 28'h2D020, 1'b0);
    pb = 3'b101; addr = 16'hA000; direct("R2", 3'd0, 28'h0A000, 1'b0);
    addr = 16'hE000; direct("R2", 3'd0, 28'h0E000, 1'b0);
    addr = 16'hD400; direct("R2", 3'd2, 28'h0D400, 1'b0);
    // R3
    clear_all(); men = 8'h02; lofs = 12'h123; addr = 16'h2345;
    direct("R3", 3'd0, 28'h14645, 1'b0);
    men = 8'h80; hofs = 12'hFFF; addr = 16'hF000; direct("R3", 3'd0, 28'h0EF00, 1'b0);
    pb = 3'b111; direct("R3", 3'd0, 28'h0EF00, 1'b0);
    // R4
    rs = 4'b1000; addr = 16'hF004; direct("R4", 3'd1, 28'h3F004, 1'b0);
    rs = 4'b0001; pb = 0; men = 0; addr = 16'h6010; direct("R4", 3'd1, 28'h30010, 1'b0);
    rs = 4'b0010; addr = 16'h9ABC; direct("R4", 3'd1, 28'h21ABC, 1'b0);
    rs = 4'b0100; addr = 16'hC100; direct("R4", 3'd1, 28'h2C100, 1'b0);
    // R5
    clear_all(); pb = 3'b111; we = 1; addr = 16'hE010; direct("R5", 3'd0, 28'h0E010, 1'b1);
    rs = 4'b1000; men = 8'h80; hofs = 12'h100; direct("R5", 3'd0, 28'h1E010, 1'b1);
    // R6 / R7
    clear_all(); men = 8'h01; lofs = 12'h300; addr = 16'h0010; we = 1;
    direct("R6", 3'd0, 28'h30010, 1'b0);
    we = 0; direct("R6", 3'd0, 28'h30010, 1'b0);
    toggle_wp(); we = 1; direct("R7", 3'd0, 28'h30010, 1'b1);
    toggle_wp(); direct("R7", 3'd0, 28'h30010, 1'b0);
    // R8
    clear_all(); pb = 3'b111; men = 8'h40; rs = 4'hF; addr = 16'hD011;
    direct("R8", 3'd2, 28'h0D011, 1'b0);
    // R9
    clear_all(); pb = 3'b111; cm = 2'd1; addr = 16'h8010; direct("R9", 3'd3, 28'h08010, 1'b0);
    we = 1; direct("R9", 3'd0, 28'h08010, 1'b1);
    we = 0; cm = 2'd2; addr = 16'hA010; direct("R9", 3'd4, 28'h0A010, 1'b0);
    cm = 2'd1; direct("R9", 3'd1, 28'h2A010, 1'b0);
    pb = 3'b101; addr = 16'h8010; direct("R9", 3'd0, 28'h08010, 1'b0);
    // R10
    clear_all(); cm = 2'd3; addr = 16'h0FFF; direct("R10", 3'd0, 28'h00FFF, 1'b0);
    addr = 16'h1000; direct("R10", 3'd5, 28'h01000, 1'b0);
    addr = 16'h8000; we = 1; direct("R10", 3'd3, 28'h08000, 1'b1);
    we = 0; addr = 16'hE000; direct("R10", 3'd4, 28'h0E000, 1'b0);
    addr = 16'hD000; direct("R10", 3'd2, 28'h0D000, 1'b0);
    addr = 16'hB000; direct("R10", 3'd5, 28'h0B000, 1'b0);
    // R11 through MAP wrap
    clear_all(); men = 8'h02; lofs = 12'hFE0; addr = 16'h2000; direct("R11", 3'd6, 28'h0, 1'b0);

    // R12: random mix
    for (int i = 0; i < 3000; i++) begin
      addr = 16'($urandom);
      we   = ($urandom_range(3) == 0);
      pb   = 3'($urandom);
      men  = ($urandom_range(1) == 0) ? 8'h00 : 8'($urandom);
      lofs = 12'($urandom);
      hofs = 12'($urandom);
      rs   = ($urandom_range(1) == 0) ? 4'h0 : 4'($urandom);
      cm   = ($urandom_range(2) == 0) ? 2'($urandom) : 2'd0;
      if ($urandom_range(15) == 0) toggle_wp();
      apply_check("R12");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule